// File: doc/BRIEF.md
# Addressed Serial Display-Data Receiver

This block receives display contents over a three-wire serial link made of an enable line, a serial clock and a data line. The block samples all three lines in its own system clock domain. While enable is low, it shifts in an 8-bit device address. When enable rises, it compares that address with its own. If the address matches, every rising edge of the serial clock during the enable-high window stores one payload bit.

When enable falls, the block counts the bits it received and checks their fixed-value fields. A good frame then updates one of two display banks. The direction bit at the end of the frame selects the bank. A frame aimed at the first bank also loads the control fields that set up the display driver: port assignment, duty, frame divider, clock source, segment blanking and power saving. A shorter compatibility frame is also accepted. It fills the banks in a slightly different layout and puts every control field except duty at its default.

The serial clock may rest high or low between transfers. Only its rising edges carry data. A controller therefore needs no configuration to select an idle level.

Top module: `serial_disp_rx`

## Requirements
- R1: After reset, both banks and all control outputs are zero, and `legacy` and `valid` are low.
- R2: While enable is low, the address is taken least-significant bit first (0,1,0,0,0,1,0,1 for 0xA2). Any other address leaves every output unchanged for the frame that follows.
- R3: A 72-bit frame whose last bit is 0 and whose bits 54..60 (0-based, in arrival order) are zero loads payload bits 0..53 into `bank_a[53:0]`. It also loads bits 61..70 as P0, P1, P2, duty, FC0, FC1, FC2, clock source, segment-off and power-save. These map to `port_cfg[0..2]`, `duty_half`, `frame_div[0..2]`, `ext_clk`, `seg_off` and `power_save`.
- R4: A 72-bit frame whose last bit is 1 and whose bits 54..70 are zero loads bits 0..53 into `bank_b`. It leaves `bank_a` and the control outputs unchanged.
- R5: A frame that has a 1 in any fixed-zero position is discarded.
- R6: A frame whose bit count is neither 72 nor 56 is discarded.
- R7: A 56-bit frame whose last bit is 0 and whose bit 54 is 0 loads bits 0..22 into `bank_a[22:0]` and bits 23..52 into `bank_a[53:24]`, and clears `bank_a[23]`. `duty_half` takes bit 53. The port, divider, clock-source, segment-off and power-save outputs are forced to 0, and `legacy` goes high.
- R8: A 56-bit frame whose last bit is 1 and whose bits 52..54 are zero loads bits 0..51 into `bank_b[51:0]` and clears `bank_b[53:52]`.
- R9: Frames are accepted with the serial clock resting high as well as resting low.
- R10: `valid` stays low until the first frame is accepted and stays high after that.
- R11: An accepted 72-bit first-bank frame clears `legacy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Serial enable: low for the address, high for the payload |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| bank_a | output | 54 | First display bank |
| bank_b | output | 54 | Second display bank |
| port_cfg | output | 3 | Port assignment code, bit 0 first received |
| duty_half | output | 1 | Half-duty drive selected |
| frame_div | output | 3 | Frame divider code, bit 0 first received |
| ext_clk | output | 1 | External clock source selected |
| seg_off | output | 1 | All segments blanked |
| power_save | output | 1 | Power-saving mode |
| legacy | output | 1 | Last first-bank frame used the short format |
| valid | output | 1 | At least one frame has been accepted |

## Verification
Distinct data and control patterns are sent to each bank. These show whether bit order, bank steering and control-field positions are correct. Each rejection case changes exactly one thing in a frame that would otherwise be good: a wrong address, a set fixed bit, or a count one below or one above 72. This shows which check discards the frame. Short frames are sent after control fields have been set to non-zero values, so that forcing the fields to defaults and dropping the omitted bit are both visible. A repeat with the clock resting high separates sampling on the clock edge from sampling on the clock level.

// File: rtl/serial_disp_rx.sv
module serial_disp_rx #(
  parameter logic [7:0] DEV_ADDR = 8'hA2,
  parameter int DISP_W = 54,
  parameter int FULL_LEN = 72,
  parameter int SHORT_LEN = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [DISP_W-1:0] bank_a,
  output logic [DISP_W-1:0] bank_b,
  output logic [2:0]        port_cfg,
  output logic              duty_half,
  output logic [2:0]        frame_div,
  output logic              ext_clk,
  output logic              seg_off,
  output logic              power_save,
  output logic              legacy,
  output logic              valid
);
  localparam int CW = $clog2(FULL_LEN + 2);
  localparam logic [CW-1:0] CMAX = CW'(FULL_LEN + 1);

  logic [2:0] s_en, s_clk, s_dat;
  logic [FULL_LEN-1:0] pay;
  logic [CW-1:0] cnt;
  logic [7:0] addr;
  logic matched;
  logic [9:0] cfg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_en <= '0; s_clk <= '0; s_dat <= '0;
    end else begin
      s_en  <= {s_en[1:0], ser_en};
      s_clk <= {s_clk[1:0], ser_clk};
      s_dat <= {s_dat[1:0], ser_dat};
    end

  wire en_rise  = s_en[1] & ~s_en[2];
  wire en_fall  = ~s_en[1] & s_en[2];
  wire clk_rise = s_clk[1] & ~s_clk[2];
  wire din      = s_dat[1];

  wire is_full  = (cnt == CW'(FULL_LEN));
  wire is_short = (cnt == CW'(SHORT_LEN));
  wire f_dir    = pay[FULL_LEN-1];
  wire s_dir    = pay[SHORT_LEN-1];
  wire ok_fa = is_full & ~f_dir & (pay[60:54] == '0);
  wire ok_fb = is_full &  f_dir & (pay[70:54] == '0);
  wire ok_sa = is_short & ~s_dir & ~pay[54];
  wire ok_sb = is_short &  s_dir & (pay[54:52] == '0);
  wire accept = en_fall & matched & (ok_fa | ok_fb | ok_sa | ok_sb);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr <= '0; matched <= 1'b0; cnt <= '0; pay <= '0;
    end else begin
      if (!s_en[1] && clk_rise) addr <= {din, addr[7:1]};
      if (en_rise) begin
        matched <= (addr == DEV_ADDR);
        cnt <= '0;
      end else if (s_en[1] && clk_rise && matched) begin
        if (cnt < CW'(FULL_LEN)) pay[cnt] <= din;
        if (cnt != CMAX) cnt <= cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bank_a <= '0; bank_b <= '0; cfg <= '0; legacy <= 1'b0; valid <= 1'b0;
    end else if (accept) begin
      valid <= 1'b1;
      if (ok_fa) begin
        bank_a <= pay[DISP_W-1:0];
        cfg    <= pay[70:61];
        legacy <= 1'b0;
      end
      if (ok_fb) bank_b <= pay[DISP_W-1:0];
      if (ok_sa) begin
        bank_a <= {pay[52:23], 1'b0, pay[22:0]};
        cfg    <= {6'b0, pay[53], 3'b0};
        legacy <= 1'b1;
      end
      if (ok_sb) bank_b <= {2'b00, pay[51:0]};
    end

  assign port_cfg   = cfg[2:0];
  assign duty_half  = cfg[3];
  assign frame_div  = cfg[6:4];
  assign ext_clk    = cfg[7];
  assign seg_off    = cfg[8];
  assign power_save = cfg[9];

  p_load_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_a != $past(bank_a)) |-> $past(en_fall));
  p_valid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);
  p_legacy_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
    legacy |-> (port_cfg == 3'b0 && frame_div == 3'b0 && !ext_clk && !seg_off && !power_save));
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX);
  p_bank_b_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_b != $past(bank_b)) |-> $past(en_fall));
endmodule

// File: tb/serial_disp_rx_tb.sv
module serial_disp_rx_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, ser_en = 0, ser_clk = 0, ser_dat = 0;
  logic [53:0] bank_a, bank_b;
  logic [2:0] port_cfg, frame_div;
  logic duty_half, ext_clk, seg_off, power_save, legacy, valid;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_disp_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .bank_a(bank_a), .bank_b(bank_b), .port_cfg(port_cfg), .duty_half(duty_half),
    .frame_div(frame_div), .ext_clk(ext_clk), .seg_off(seg_off), .power_save(power_save),
    .legacy(legacy), .valid(valid));

  localparam logic [53:0] DA1 = 54'h0A5A5AF00F1234;
  localparam logic [53:0] DA2 = 54'h3C3C3C0FF0A5C3;
  localparam logic [53:0] DB1 = 54'h2123456789ABCD;
  localparam logic [53:0] DA3 = 54'h155555AAAA5555;
  localparam logic [53:0] DB2 = 54'h3FFFFFFFFFFFFF;
  localparam logic [9:0]  CF1 = 10'b1110101100;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b, input bit hi);
    if (hi) begin
      ser_clk = 0; ser_dat = b; wait_n(4); ser_clk = 1; wait_n(4);
    end else begin
      ser_dat = b; wait_n(4); ser_clk = 1; wait_n(4); ser_clk = 0;
    end
  endtask

  task automatic xfer(input logic [7:0] a, input logic [71:0] p, input int n, input bit hi);
    ser_en = 0; ser_clk = hi; wait_n(8);
    for (int i = 0; i < 8; i++) bit_out(a[i], hi);
    wait_n(4); ser_en = 1; wait_n(4);
    for (int i = 0; i < n; i++) bit_out((i < 72) ? p[i] : 1'b0, hi);
    wait_n(4); ser_en = 0; wait_n(12);
  endtask

  function automatic logic [71:0] full_a(input logic [53:0] d, input logic [9:0] c);
    return {1'b0, c, 7'b0, d};
  endfunction
  function automatic logic [71:0] full_b(input logic [53:0] d);
    return {1'b1, 17'b0, d};
  endfunction
  function automatic logic [71:0] short_a(input logic [53:0] d, input logic dt);
    return {16'b0, 1'b0, 1'b0, dt, d[53:24], d[22:0]};
  endfunction
  function automatic logic [71:0] short_b(input logic [51:0] d);
    return {16'b0, 1'b1, 3'b0, d};
  endfunction

  task automatic t_reset;
    check("R1 bank_a", 64'(bank_a), 0);
    check("R1 bank_b", 64'(bank_b), 0);
    check("R1 ctrl", 64'({port_cfg, duty_half, frame_div, ext_clk, seg_off, power_save, legacy}), 0);
    check("R10 valid low", 64'(valid), 0);
  endtask

  task automatic t_full_a;
    xfer(8'hA2, full_a(DA1, CF1), 72, 0);
    check("R3 bank_a", 64'(bank_a), 64'(DA1));
    check("R3 port_cfg", 64'(port_cfg), 64'(3'b100));
    check("R3 duty", 64'(duty_half), 1);
    check("R3 frame_div", 64'(frame_div), 64'(3'b010));
    check("R3 ext/seg/save", 64'({ext_clk, seg_off, power_save}), 64'(3'b111));
    check("R10 valid high", 64'(valid), 1);
  endtask

  task automatic t_full_b;
    xfer(8'hA2, full_b(DB1), 72, 0);
    check("R4 bank_b", 64'(bank_b), 64'(DB1));
    check("R4 bank_a kept", 64'(bank_a), 64'(DA1));
    check("R4 port_cfg kept", 64'(port_cfg), 64'(3'b100));
  endtask

  task automatic t_bad_addr;
    xfer(8'hA3, full_a(DA2, 10'b0), 72, 0);
    check("R2 wrong address ignored", 64'(bank_a), 64'(DA1));
    check("R2 ctrl kept", 64'(frame_div), 64'(3'b010));
  endtask

  task automatic t_bad_fixed;
    logic [71:0] p;
    p = full_a(DA2, 10'b0);
    p[57] = 1'b1;
    xfer(8'hA2, p, 72, 0);
    check("R5 fixed bit set discards", 64'(bank_a), 64'(DA1));
    p = full_b(DA2);
    p[70] = 1'b1;
    xfer(8'hA2, p, 72, 0);
    check("R5 fixed bit set in bank-b frame", 64'(bank_b), 64'(DB1));
  endtask

  task automatic t_bad_len;
    xfer(8'hA2, full_a(DA2, 10'b0), 71, 0);
    check("R6 71 bits discarded", 64'(bank_a), 64'(DA1));
    xfer(8'hA2, full_a(DA2, 10'b0), 73, 0);
    check("R6 73 bits discarded", 64'(bank_a), 64'(DA1));
  endtask

  task automatic t_idle_high;
    xfer(8'hA2, full_a(DA2, CF1), 72, 1);
    check("R9 clock idle high", 64'(bank_a), 64'(DA2));
  endtask

  task automatic t_short_a;
    logic [53:0] e;
    e = DA3;
    e[23] = 1'b0;
    xfer(8'hA2, short_a(DA3, 1'b1), 56, 0);
    check("R7 bank_a layout", 64'(bank_a), 64'(e));
    check("R7 duty from frame", 64'(duty_half), 1);
    check("R7 forced defaults", 64'({port_cfg, frame_div, ext_clk, seg_off, power_save}), 0);
    check("R7 legacy set", 64'(legacy), 1);
  endtask

  task automatic t_short_b;
    xfer(8'hA2, full_b(DB2), 72, 0);
    check("R4 bank_b all ones", 64'(bank_b), 64'(DB2));
    xfer(8'hA2, short_b(52'h0_1234_5678_9ABC), 56, 0);
    check("R8 bank_b short", 64'(bank_b), 64'h0_0001_2345_6789_ABC);
    check("R8 legacy kept", 64'(legacy), 1);
  endtask

  task automatic t_clear_legacy;
    xfer(8'hA2, full_a(DA1, CF1), 72, 0);
    check("R11 legacy cleared", 64'(legacy), 0);
    check("R11 bank_a reloaded", 64'(bank_a), 64'(DA1));
  endtask

  initial begin
    wait_n(3);
    t_reset;
    rst_n = 1;
    wait_n(3);
    t_reset;
    t_full_a;
    t_full_b;
    t_bad_addr;
    t_bad_fixed;
    t_bad_len;
    t_idle_high;
    t_short_a;
    t_short_b;
    t_clear_legacy;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule